// File: doc/BRIEF.md
# Microcontroller Bus Glue with Banked ROM

This block sits on the address and data bus of a small 8-bit microcontroller. It adds a window of expansion RAM and a small set of port registers at low addresses. It also holds a one-bit bank register that drives the upper address line of an external ROM. A single decoder, gated by the CPU's active-high chip enable, covers all of these targets. The same decoder produces a ROM select for the rest of the space above the RAM window, and a select for the block's own registers.

The port registers are:

- an output-only address port;
- a bidirectional data port with its own per-bit direction register;
- an output-only control port;
- the bank bit.

The block has no tri-state buffers. The CPU data bus is split into a write-data input, a read-data output and an output enable. The bidirectional port has separate pin-in, pin-out and per-bit output-enable signals. Every read goes through one register stage. Read data and the bus enable appear in the cycle after the edge that samples the read.

Top module: `busGlue`

## Requirements
- R1: After reset, the address port, control port, data latch, direction register and bank bit are all 0, and the data-bus output enable is low.
- R2: Addresses 0x0140 to 0x01FF form 192 bytes of RAM. A write there stores the byte. A read there returns that byte on `cpuRdData` with `cpuRdOe` high in the cycle after the edge that samples the read.
- R3: A write to 0x0020 sets `addrPort`. A read of 0x0020 returns the latched value.
- R4: A write to 0x0022 sets the direction register. A 1 in bit n drives `dataPortOe[n]` high, so pin n is an output. A 0 leaves pin n an input. Reading 0x0022 returns the register. `dataPortOe` changes only on a write to 0x0022.
- R5: A write to 0x0021 sets the data latch, which drives `dataPortOut`. A read of 0x0021 returns, for each bit, the latch where the direction bit is 1 and `dataPortIn` where it is 0.
- R6: A write to 0x0023 sets `ctrlPort`. A read of 0x0023 returns the latched value.
- R7: A write to 0x0024 stores bit 0 of the written byte. That bit drives `romBank`, the upper ROM address line. A read of 0x0024 returns the bit with bits 7..1 at 0. `romBank` changes only on a write to 0x0024.
- R8: `romSel` is high exactly when chip enable is high and the address is from 0x0200 to 0x3FFF. This range includes the reset vector bytes 0x1FFE and 0x1FFF. It is low for the RAM window and for all lower addresses.
- R9: `regSel` is high exactly when chip enable is high and the address is from 0x0020 to 0x0024.
- R10: With chip enable low, nothing is decoded: `romSel` and `regSel` are low, writes change no register, and reads do not drive the bus.
- R11: `cpuRdOe` is high only in the cycle after a sampled read with chip enable high to a block register or to RAM. A read of ROM space or of an unclaimed low address such as 0x0025 leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 14 | CPU address |
| cpuCe | input | 1 | CPU chip enable, active high |
| cpuWe | input | 1 | 1 = write cycle, 0 = read cycle |
| cpuWrData | input | 8 | Data written by the CPU |
| cpuRdData | output | 8 | Data returned to the CPU |
| cpuRdOe | output | 1 | Block drives the CPU data bus |
| addrPort | output | 8 | Output-only address port |
| ctrlPort | output | 8 | Output-only control port |
| dataPortIn | input | 8 | Bidirectional port pin levels |
| dataPortOut | output | 8 | Bidirectional port output latch |
| dataPortOe | output | 8 | Per-bit output enable of the bidirectional port |
| romBank | output | 1 | Upper ROM address line (bank select) |
| romSel | output | 1 | ROM select |
| regSel | output | 1 | Block register select |

## Verification
The assertions take a well-formed bus for granted. Chip enable, write strobe and address are stable around each sampling edge. A read cycle has the write strobe low, so a cycle is never both a read and a write. The bench drives every bus input on the falling clock edge and holds it for a full cycle, so each rising edge sees one settled access. It also returns chip enable low between accesses. The per-bit output enables and the bank line are expected to move only in the cycle after a write to their own addresses, and the bench issues no other access that could disturb them.

// File: rtl/busGluePkg.sv
package busGluePkg;

  // Which source feeds the registered read path
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ADDRP,
    SEL_DATA,
    SEL_DIR,
    SEL_CTRL,
    SEL_BANK,
    SEL_RAM
  } rdSel_e;

  // Strobes from decoder to datapath
  typedef struct packed {
    logic   wrAddrP;
    logic   wrData;
    logic   wrDir;
    logic   wrCtrl;
    logic   wrBank;
    logic   wrRam;
    logic   rdEn;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/busGlueCtrl.sv
module busGlueCtrl
  import busGluePkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int RAM_BASE  = 'h140,
  parameter int RAM_DEPTH = 192,
  parameter int REG_BASE  = 'h20,
  parameter int RAM_IDX_W = $clog2(RAM_DEPTH)
) (
  input  logic [ADDR_W-1:0]    cpuAddr,
  input  logic                 cpuCe,
  input  logic                 cpuWe,
  output strobe_t              strobe,
  output logic [RAM_IDX_W-1:0] ramIdx,
  output logic                 romSel,
  output logic                 regSel
);

  localparam int NUM_REGS = 5;
  localparam logic [ADDR_W-1:0] RAM_LO = ADDR_W'(RAM_BASE);
  localparam logic [ADDR_W-1:0] RAM_HI = ADDR_W'(RAM_BASE + RAM_DEPTH - 1);
  localparam logic [ADDR_W-1:0] REG_LO = ADDR_W'(REG_BASE);
  localparam logic [ADDR_W-1:0] REG_HI = ADDR_W'(REG_BASE + NUM_REGS - 1);

  logic inRam, inReg, aboveRam;
  rdSel_e target;

  always_comb begin
    inRam    = (cpuAddr >= RAM_LO) && (cpuAddr <= RAM_HI);
    aboveRam = cpuAddr > RAM_HI;
    inReg    = (cpuAddr >= REG_LO) && (cpuAddr <= REG_HI);
    ramIdx   = RAM_IDX_W'(cpuAddr - RAM_LO);

    target = SEL_NONE;
    if (inRam) target = SEL_RAM;
    else if (cpuAddr == ADDR_W'(REG_BASE + 0)) target = SEL_ADDRP;
    else if (cpuAddr == ADDR_W'(REG_BASE + 1)) target = SEL_DATA;
    else if (cpuAddr == ADDR_W'(REG_BASE + 2)) target = SEL_DIR;
    else if (cpuAddr == ADDR_W'(REG_BASE + 3)) target = SEL_CTRL;
    else if (cpuAddr == ADDR_W'(REG_BASE + 4)) target = SEL_BANK;

    romSel = cpuCe && aboveRam;
    regSel = cpuCe && inReg;

    strobe.wrAddrP = cpuCe && cpuWe && (target == SEL_ADDRP);
    strobe.wrData  = cpuCe && cpuWe && (target == SEL_DATA);
    strobe.wrDir   = cpuCe && cpuWe && (target == SEL_DIR);
    strobe.wrCtrl  = cpuCe && cpuWe && (target == SEL_CTRL);
    strobe.wrBank  = cpuCe && cpuWe && (target == SEL_BANK);
    strobe.wrRam   = cpuCe && cpuWe && (target == SEL_RAM);
    strobe.rdEn    = cpuCe && !cpuWe && (target != SEL_NONE);
    strobe.rdSel   = cpuCe ? target : SEL_NONE;
  end

endmodule

// File: rtl/busGlueDatapath.sv
module busGlueDatapath
  import busGluePkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int RAM_DEPTH = 192,
  parameter int RAM_IDX_W = $clog2(RAM_DEPTH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  input  logic [RAM_IDX_W-1:0] ramIdx,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [DATA_W-1:0]    pinIn,
  output logic [DATA_W-1:0]    rdData,
  output logic                 rdOe,
  output logic [DATA_W-1:0]    addrLatch,
  output logic [DATA_W-1:0]    ctrlLatch,
  output logic [DATA_W-1:0]    dataLatch,
  output logic [DATA_W-1:0]    dirReg,
  output logic                 bankBit
);

  logic [DATA_W-1:0] mem [RAM_DEPTH];
  logic [DATA_W-1:0] portView;
  logic [DATA_W-1:0] rdNext;

  // Per-bit choice between latch (output bit) and pin (input bit)
  for (genvar b = 0; b < DATA_W; b++) begin : g_portBit
    assign portView[b] = dirReg[b] ? dataLatch[b] : pinIn[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLatch <= '0;
      ctrlLatch <= '0;
      dataLatch <= '0;
      dirReg    <= '0;
      bankBit   <= 1'b0;
    end else begin
      if (strobe.wrAddrP) addrLatch <= wrData;
      if (strobe.wrCtrl)  ctrlLatch <= wrData;
      if (strobe.wrData)  dataLatch <= wrData;
      if (strobe.wrDir)   dirReg    <= wrData;
      if (strobe.wrBank)  bankBit   <= wrData[0];
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.wrRam) mem[ramIdx] <= wrData;
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_ADDRP: rdNext = addrLatch;
      SEL_DATA:  rdNext = portView;
      SEL_DIR:   rdNext = dirReg;
      SEL_CTRL:  rdNext = ctrlLatch;
      SEL_BANK:  rdNext = {{(DATA_W-1){1'b0}}, bankBit};
      SEL_RAM:   rdNext = mem[ramIdx];
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      rdOe   <= 1'b0;
    end else begin
      rdOe <= strobe.rdEn;
      if (strobe.rdEn) rdData <= rdNext;
    end
  end

endmodule

// File: rtl/busGlue.sv
module busGlue
  import busGluePkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int DATA_W    = 8,
  parameter int RAM_BASE  = 'h140,
  parameter int RAM_DEPTH = 192,
  parameter int REG_BASE  = 'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuCe,
  input  logic              cpuWe,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [DATA_W-1:0] cpuRdData,
  output logic              cpuRdOe,
  output logic [DATA_W-1:0] addrPort,
  output logic [DATA_W-1:0] ctrlPort,
  input  logic [DATA_W-1:0] dataPortIn,
  output logic [DATA_W-1:0] dataPortOut,
  output logic [DATA_W-1:0] dataPortOe,
  output logic              romBank,
  output logic              romSel,
  output logic              regSel
);

  localparam int RAM_IDX_W = $clog2(RAM_DEPTH);

  strobe_t              strobe;
  logic [RAM_IDX_W-1:0] ramIdx;

  busGlueCtrl #(
    .ADDR_W(ADDR_W), .RAM_BASE(RAM_BASE), .RAM_DEPTH(RAM_DEPTH),
    .REG_BASE(REG_BASE), .RAM_IDX_W(RAM_IDX_W)
  ) u_ctrl (
    .cpuAddr(cpuAddr), .cpuCe(cpuCe), .cpuWe(cpuWe),
    .strobe(strobe), .ramIdx(ramIdx), .romSel(romSel), .regSel(regSel)
  );

  busGlueDatapath #(
    .DATA_W(DATA_W), .RAM_DEPTH(RAM_DEPTH), .RAM_IDX_W(RAM_IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ramIdx(ramIdx),
    .wrData(cpuWrData), .pinIn(dataPortIn),
    .rdData(cpuRdData), .rdOe(cpuRdOe),
    .addrLatch(addrPort), .ctrlLatch(ctrlPort),
    .dataLatch(dataPortOut), .dirReg(dataPortOe), .bankBit(romBank)
  );

endmodule

// File: rtl/busGlueChecker.sv
module busGlueChecker #(
  parameter int ADDR_W   = 14,
  parameter int DATA_W   = 8,
  parameter int REG_BASE = 'h20
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              cpuCe,
  input logic              cpuWe,
  input logic [DATA_W-1:0] dataPortOe,
  input logic              romBank,
  input logic              romSel,
  input logic              regSel,
  input logic              cpuRdOe
);

  localparam logic [ADDR_W-1:0] DIR_ADDR  = ADDR_W'(REG_BASE + 2);
  localparam logic [ADDR_W-1:0] BANK_ADDR = ADDR_W'(REG_BASE + 4);

  // R10: no decode without chip enable
  p_no_decode_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cpuCe |-> (!romSel && !regSel));

  // R8 / R9: the two selects never overlap
  p_sel_disjoint_r8: assert property (@(posedge clk) disable iff (!rstN)
    romSel |-> !regSel);

  // R11: bus driven only after a qualified read
  p_oe_after_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    cpuRdOe |-> $past(cpuCe && !cpuWe));

  // R4: direction changes only after a direction write
  p_dir_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataPortOe) |-> $past(cpuCe && cpuWe && cpuAddr == DIR_ADDR));

  // R7: bank line changes only after a bank write
  p_bank_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(romBank) |-> $past(cpuCe && cpuWe && cpuAddr == BANK_ADDR));

endmodule

bind busGlue busGlueChecker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_BASE(REG_BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuCe(cpuCe), .cpuWe(cpuWe),
  .dataPortOe(dataPortOe), .romBank(romBank), .romSel(romSel),
  .regSel(regSel), .cpuRdOe(cpuRdOe)
);

// File: tb/sim_busGlue.sv
`timescale 1ns/1ps
module sim_busGlue;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [13:0] cpuAddr = '0;
  logic        cpuCe = 1'b0;
  logic        cpuWe = 1'b0;
  logic [7:0]  cpuWrData = '0;
  logic [7:0]  cpuRdData;
  logic        cpuRdOe;
  logic [7:0]  addrPort, ctrlPort, dataPortOut, dataPortOe;
  logic [7:0]  dataPortIn = '0;
  logic        romBank, romSel, regSel;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  always #4 clk = ~clk;

  busGlue u0 (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuCe(cpuCe), .cpuWe(cpuWe),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData), .cpuRdOe(cpuRdOe),
    .addrPort(addrPort), .ctrlPort(ctrlPort), .dataPortIn(dataPortIn),
    .dataPortOut(dataPortOut), .dataPortOe(dataPortOe),
    .romBank(romBank), .romSel(romSel), .regSel(regSel)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [13:0] a, input logic [7:0] d, input bit ce = 1);
    @(negedge clk);
    cpuAddr = a; cpuWrData = d; cpuWe = 1'b1; cpuCe = ce;
    @(negedge clk);
    cpuCe = 1'b0; cpuWe = 1'b0;
  endtask

  // Driver: push the expected byte, then issue the read
  task automatic busRead(input logic [13:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    expQ.push_back(exp); tagQ.push_back(tag);
    cpuAddr = a; cpuWe = 1'b0; cpuCe = 1'b1;
    @(negedge clk);
    cpuCe = 1'b0;
  endtask

  // Read that must not drive the bus
  task automatic quietRead(input logic [13:0] a, input bit ce, input string tag);
    @(negedge clk);
    cpuAddr = a; cpuWe = 1'b0; cpuCe = ce;
    @(negedge clk);
    cpuCe = 1'b0;
    chk(cpuRdOe == 1'b0, tag, cpuRdOe, 0);
  endtask

  task automatic decodeChk(input logic [13:0] a, input bit ce, input bit expRom,
                           input bit expReg, input string tag);
    @(negedge clk);
    cpuAddr = a; cpuWe = 1'b0; cpuCe = ce;
    #1;
    chk(romSel == expRom, {tag, " romSel"}, romSel, expRom);
    chk(regSel == expReg, {tag, " regSel"}, regSel, expReg);
    cpuCe = 1'b0;
  endtask

  // Monitor: compare each driven read with the queue head
  always @(posedge clk) begin
    #2;
    if (rstN && cpuRdOe) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R11 unexpected bus drive", cpuRdData, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front(); t = tagQ.pop_front();
        chk(cpuRdData == e, t, cpuRdData, e);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(addrPort == 0 && ctrlPort == 0, "R1 ports", {addrPort, ctrlPort}, 0);
    chk(dataPortOut == 0 && dataPortOe == 0, "R1 data port", {dataPortOut, dataPortOe}, 0);
    chk(romBank == 0 && cpuRdOe == 0, "R1 bank/oe", {romBank, cpuRdOe}, 0);
    rstN = 1'b1;
    busRead(14'h22, 8'h00, "R1 dir readback");
    busRead(14'h24, 8'h00, "R1 bank readback");

    // R3 address port
    busWrite(14'h20, 8'hA5);
    chk(addrPort == 8'hA5, "R3 pins", addrPort, 8'hA5);
    busRead(14'h20, 8'hA5, "R3 readback");

    // R6 control port
    busWrite(14'h23, 8'h3C);
    chk(ctrlPort == 8'h3C, "R6 pins", ctrlPort, 8'h3C);
    busRead(14'h23, 8'h3C, "R6 readback");

    // R4 / R5 bidirectional port
    dataPortIn = 8'h5A;
    busWrite(14'h22, 8'hF0);
    chk(dataPortOe == 8'hF0, "R4 oe", dataPortOe, 8'hF0);
    busWrite(14'h21, 8'h96);
    chk(dataPortOut == 8'h96, "R5 latch pins", dataPortOut, 8'h96);
    chk(dataPortOe == 8'hF0, "R4 oe held", dataPortOe, 8'hF0);
    busRead(14'h21, 8'h9A, "R5 mixed read");
    busRead(14'h22, 8'hF0, "R4 readback");
    busWrite(14'h22, 8'h00);
    dataPortIn = 8'hC3;
    busRead(14'h21, 8'hC3, "R5 all-input read");
    busWrite(14'h22, 8'hFF);
    busRead(14'h21, 8'h96, "R5 all-output read");

    // R7 bank
    busWrite(14'h24, 8'hFF);
    chk(romBank == 1'b1, "R7 bank set", romBank, 1);
    busRead(14'h24, 8'h01, "R7 upper bits zero");
    busWrite(14'h24, 8'hFE);
    chk(romBank == 1'b0, "R7 bank clear", romBank, 0);

    // R2 RAM, full window
    for (int i = 0; i < 192; i++) busWrite(14'h140 + 14'(i), 8'((i * 7 + 3) & 8'hFF));
    for (int i = 0; i < 192; i++) busRead(14'h140 + 14'(i), 8'((i * 7 + 3) & 8'hFF), "R2 ram");
    busWrite(14'h1FF, 8'h5E);
    busRead(14'h1FF, 8'h5E, "R2 top byte");
    busRead(14'h140, 8'h03, "R2 bottom byte");

    // R8 / R9 decode
    decodeChk(14'h1FFE, 1, 1, 0, "R8 vector hi");
    decodeChk(14'h1FFF, 1, 1, 0, "R8 vector lo");
    decodeChk(14'h0200, 1, 1, 0, "R8 rom start");
    decodeChk(14'h3FFF, 1, 1, 0, "R8 rom end");
    decodeChk(14'h01FF, 1, 0, 0, "R8 ram end");
    decodeChk(14'h0140, 1, 0, 0, "R8 ram start");
    decodeChk(14'h013F, 1, 0, 0, "R8 below ram");
    decodeChk(14'h0020, 1, 0, 1, "R9 first reg");
    decodeChk(14'h0024, 1, 0, 1, "R9 last reg");
    decodeChk(14'h0025, 1, 0, 0, "R9 past regs");
    decodeChk(14'h001F, 1, 0, 0, "R9 below regs");

    // R10 chip enable gating
    decodeChk(14'h1FFE, 0, 0, 0, "R10 rom no ce");
    decodeChk(14'h0021, 0, 0, 0, "R10 reg no ce");
    busWrite(14'h20, 8'h11, 0);
    chk(addrPort == 8'hA5, "R10 write ignored", addrPort, 8'hA5);
    quietRead(14'h20, 0, "R10 read no ce");

    // R11 no drive for rom / unclaimed
    quietRead(14'h3000, 1, "R11 rom read");
    quietRead(14'h0025, 1, "R11 unclaimed read");

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R11 missing reads", expQ.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule